// File: doc/BRIEF.md
# FIFO Loopback Path Controller

This block sits between two FIFOs and a shared bidirectional data port. In normal operation the port either writes words into the destination FIFO or reads words out of the source FIFO, depending on a direction select. When the loop enable is active, the controller instead pops the source FIFO and pushes each popped word straight into the destination FIFO, one word per clock. Looped words are also driven onto the port when the port is set for reading.

The loop has asymmetric stop rules. If the destination fills while the source still holds data, the controller keeps popping the source, but only in read mode, and the words go to the port alone. If the source drains while the destination has room, the controller keeps writing the last word it popped into the destination until the destination fills or the loop is switched off. The loop enable is registered, so starting and stopping take effect on the clock edge after the enable changes. Both FIFOs are assumed to present their head word while they are not empty, and to consume it on the cycle their pop strobe is high.

Top module: `lpbk_ctrl`

## Requirements
- R1: After reset, with the loop enable low and both external strobes low, the source pop, the destination write and the port output enable are all low.
- R2: The loop enable is sampled on the rising clock edge. Looping starts in the cycle after the edge that first sees it high, and ends in the cycle after the edge that first sees it low.
- R3: While looping with the source not empty and the destination not full, the block pops the source and writes the destination in the same cycle, and the written data equals the source head word.
- R4: While looping with the port direction select at 0 (the port writes), the port output enable stays low.
- R5: While looping with the direction select at 1 (the port reads), every source pop drives the port output enable high, and the port data equals the popped word.
- R6: While looping with the destination full and the direction select at 1, the source is still popped and the word goes to the port only. The destination write stays low.
- R7: While looping with the destination full and the direction select at 0, there is no source pop, no destination write and no port output enable.
- R8: While looping with the source empty and the destination not full, the destination is written with the last word popped since the loop started. No pop occurs and the port output enable is low. The write stops once the destination is full.
- R9: While looping, if no word has been popped since the loop started and the source is empty, nothing is written to the destination.
- R10: With the loop inactive and the direction select at 1, the source is popped exactly when the external read strobe is high and the source is not empty. The port output enable follows that pop and carries the head word. The external write strobe is ignored.
- R11: With the loop inactive and the direction select at 0, the destination is written with the external data exactly when the external write strobe is high and the destination is not full. The external read strobe is ignored and the port output enable is low.
- R12: At most one word moves per clock in each direction. A pop never occurs while the source is empty, and a write never occurs while the destination is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| loop_en | input | 1 | Loopback enable, registered before use |
| port_rd_mode | input | 1 | Port direction select: 1 = port reads (block drives it), 0 = port writes |
| ext_rd_en | input | 1 | External read strobe from the port side |
| ext_wr_en | input | 1 | External write strobe from the port side |
| ext_wr_data | input | DATA_W | Data written from the port |
| src_not_empty | input | 1 | Source FIFO holds at least one word |
| src_data | input | DATA_W | Source FIFO head word |
| src_rd_en | output | 1 | Source FIFO pop |
| dst_not_full | input | 1 | Destination FIFO has a free location |
| dst_wr_en | output | 1 | Destination FIFO push |
| dst_wr_data | output | DATA_W | Destination FIFO write data |
| port_oe | output | 1 | Port output enable |
| port_out | output | DATA_W | Data driven onto the port |

## Verification
The assertions take for granted that the FIFO status inputs are honest. The head word must be meaningful whenever the not-empty flag is high, and the flags may change between any two clock edges. They also take for granted that the direction select and the strobes are steady from shortly after one falling edge to past the next rising edge. The stimulus changes every input only just after the falling clock edge, and it moves the FIFO flags by hand to reach each stop condition. It never models a FIFO whose flags contradict the pops and writes the block has made.

// File: rtl/lpbk_pkg.sv
`timescale 1ns/1ps
package lpbk_pkg;
  typedef enum logic [2:0] {
    RT_IDLE,
    RT_PASS,
    RT_LOOP,
    RT_PORT_ONLY,
    RT_REFILL
  } route_t;
endpackage

// File: rtl/lpbk_rst_sync.sv
`timescale 1ns/1ps
module lpbk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/lpbk_hold.sv
`timescale 1ns/1ps
module lpbk_hold #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loop_en,
  input  logic              loop_pop,
  input  logic [DATA_W-1:0] pop_data,
  output logic              loop_act,
  output logic              have_last,
  output logic [DATA_W-1:0] last_word
);
  logic              loop_act_d;
  logic              have_last_d;
  logic              last_ce;

  always_comb begin
    loop_act_d  = loop_en;
    have_last_d = loop_act ? (have_last | loop_pop) : 1'b0;
    last_ce     = loop_act & loop_pop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_act  <= 1'b0;
      have_last <= 1'b0;
    end else begin
      loop_act  <= loop_act_d;
      have_last <= have_last_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_word <= '0;
    else if (last_ce) last_word <= pop_data;
  end
endmodule

// File: rtl/lpbk_route.sv
`timescale 1ns/1ps
module lpbk_route
  import lpbk_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              loop_act,
  input  logic              have_last,
  input  logic [DATA_W-1:0] last_word,
  input  logic              port_rd_mode,
  input  logic              ext_rd_en,
  input  logic              ext_wr_en,
  input  logic [DATA_W-1:0] ext_wr_data,
  input  logic              src_not_empty,
  input  logic [DATA_W-1:0] src_data,
  input  logic              dst_not_full,
  output logic              src_rd_en,
  output logic              dst_wr_en,
  output logic [DATA_W-1:0] dst_wr_data,
  output logic              port_oe,
  output logic [DATA_W-1:0] port_out
);
  route_t route;

  always_comb begin
    if (!loop_act)                      route = RT_PASS;
    else if (src_not_empty && dst_not_full) route = RT_LOOP;
    else if (src_not_empty)             route = RT_PORT_ONLY;
    else if (dst_not_full && have_last) route = RT_REFILL;
    else                                route = RT_IDLE;
  end

  always_comb begin
    src_rd_en   = 1'b0;
    dst_wr_en   = 1'b0;
    dst_wr_data = src_data;
    port_oe     = 1'b0;
    port_out    = src_data;
    unique case (route)
      RT_PASS: begin
        if (port_rd_mode) begin
          src_rd_en = ext_rd_en & src_not_empty;
          port_oe   = ext_rd_en & src_not_empty;
        end else begin
          dst_wr_en   = ext_wr_en & dst_not_full;
          dst_wr_data = ext_wr_data;
        end
      end
      RT_LOOP: begin
        src_rd_en = 1'b1;
        dst_wr_en = 1'b1;
        port_oe   = port_rd_mode;
      end
      RT_PORT_ONLY: begin
        src_rd_en = port_rd_mode;
        port_oe   = port_rd_mode;
      end
      RT_REFILL: begin
        dst_wr_en   = 1'b1;
        dst_wr_data = last_word;
      end
      default: begin
        src_rd_en = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/lpbk_ctrl.sv
`timescale 1ns/1ps
module lpbk_ctrl #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loop_en,
  input  logic              port_rd_mode,
  input  logic              ext_rd_en,
  input  logic              ext_wr_en,
  input  logic [DATA_W-1:0] ext_wr_data,
  input  logic              src_not_empty,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_rd_en,
  input  logic              dst_not_full,
  output logic              dst_wr_en,
  output logic [DATA_W-1:0] dst_wr_data,
  output logic              port_oe,
  output logic [DATA_W-1:0] port_out
);
  logic              rst_n_sync;
  logic              loop_act;
  logic              have_last;
  logic [DATA_W-1:0] last_word;
  logic              loop_pop;

  assign loop_pop = src_rd_en;

  lpbk_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  lpbk_hold #(.DATA_W(DATA_W)) hold_i (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .loop_en   (loop_en),
    .loop_pop  (loop_pop),
    .pop_data  (src_data),
    .loop_act  (loop_act),
    .have_last (have_last),
    .last_word (last_word)
  );

  lpbk_route #(.DATA_W(DATA_W)) route_i (
    .loop_act      (loop_act),
    .have_last     (have_last),
    .last_word     (last_word),
    .port_rd_mode  (port_rd_mode),
    .ext_rd_en     (ext_rd_en),
    .ext_wr_en     (ext_wr_en),
    .ext_wr_data   (ext_wr_data),
    .src_not_empty (src_not_empty),
    .src_data      (src_data),
    .dst_not_full  (dst_not_full),
    .src_rd_en     (src_rd_en),
    .dst_wr_en     (dst_wr_en),
    .dst_wr_data   (dst_wr_data),
    .port_oe       (port_oe),
    .port_out      (port_out)
  );
endmodule

// File: rtl/lpbk_ctrl_chk.sv
`timescale 1ns/1ps
module lpbk_ctrl_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n_sync,
  input logic              loop_act,
  input logic              port_rd_mode,
  input logic              ext_rd_en,
  input logic              src_not_empty,
  input logic [DATA_W-1:0] src_data,
  input logic              dst_not_full,
  input logic              src_rd_en,
  input logic              dst_wr_en,
  input logic [DATA_W-1:0] dst_wr_data,
  input logic              port_oe,
  input logic [DATA_W-1:0] port_out
);
  assert_pop_needs_data_R12: assert property (@(posedge clk) disable iff (!rst_n_sync)
    src_rd_en |-> src_not_empty);

  assert_write_needs_room_R12: assert property (@(posedge clk) disable iff (!rst_n_sync)
    dst_wr_en |-> dst_not_full);

  assert_loop_copy_R3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (loop_act && src_rd_en && dst_wr_en) |-> (dst_wr_data == src_data));

  assert_port_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (loop_act && !port_rd_mode) |-> !port_oe);

  assert_port_drive_R5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (loop_act && port_rd_mode && src_rd_en) |-> (port_oe && port_out == src_data));

  assert_refill_no_pop_R8: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (loop_act && !src_not_empty) |-> (!src_rd_en && !port_oe));

  assert_pass_read_R10: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!loop_act && port_rd_mode) |-> (src_rd_en == (ext_rd_en && src_not_empty)));

  assert_pass_write_R11: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!loop_act && !port_rd_mode) |-> (!src_rd_en && !port_oe));
endmodule

bind lpbk_ctrl lpbk_ctrl_chk #(.DATA_W(DATA_W)) chk_i (
  .clk           (clk),
  .rst_n_sync    (rst_n_sync),
  .loop_act      (loop_act),
  .port_rd_mode  (port_rd_mode),
  .ext_rd_en     (ext_rd_en),
  .src_not_empty (src_not_empty),
  .src_data      (src_data),
  .dst_not_full  (dst_not_full),
  .src_rd_en     (src_rd_en),
  .dst_wr_en     (dst_wr_en),
  .dst_wr_data   (dst_wr_data),
  .port_oe       (port_oe),
  .port_out      (port_out)
);

// File: tb/lpbk_ctrl_tb.sv
`timescale 1ns/1ps
module lpbk_ctrl_tb_top;
  localparam int DATA_W = 36;

  logic              clk;
  logic              rst_n;
  logic              loop_en;
  logic              port_rd_mode;
  logic              ext_rd_en;
  logic              ext_wr_en;
  logic [DATA_W-1:0] ext_wr_data;
  logic              src_not_empty;
  logic [DATA_W-1:0] src_data;
  logic              src_rd_en;
  logic              dst_not_full;
  logic              dst_wr_en;
  logic [DATA_W-1:0] dst_wr_data;
  logic              port_oe;
  logic [DATA_W-1:0] port_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  lpbk_ctrl #(.DATA_W(DATA_W)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .loop_en       (loop_en),
    .port_rd_mode  (port_rd_mode),
    .ext_rd_en     (ext_rd_en),
    .ext_wr_en     (ext_wr_en),
    .ext_wr_data   (ext_wr_data),
    .src_not_empty (src_not_empty),
    .src_data      (src_data),
    .src_rd_en     (src_rd_en),
    .dst_not_full  (dst_not_full),
    .dst_wr_en     (dst_wr_en),
    .dst_wr_data   (dst_wr_data),
    .port_oe       (port_oe),
    .port_out      (port_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic inputs_idle();
    loop_en       = 1'b0;
    port_rd_mode  = 1'b0;
    ext_rd_en     = 1'b0;
    ext_wr_en     = 1'b0;
    ext_wr_data   = '0;
    src_not_empty = 1'b0;
    src_data      = '0;
    dst_not_full  = 1'b0;
  endtask

  task automatic t_reset();
    settle();
    chk("R1", "src_rd_en", src_rd_en, 0);
    chk("R1", "dst_wr_en", dst_wr_en, 0);
    chk("R1", "port_oe", port_oe, 0);
    tick();
    src_not_empty = 1'b1; dst_not_full = 1'b1; settle();
    chk("R1", "src_rd_en flags set", src_rd_en, 0);
    chk("R1", "dst_wr_en flags set", dst_wr_en, 0);
  endtask

  task automatic t_pass_read();
    tick();
    port_rd_mode = 1'b1; ext_rd_en = 1'b1; ext_wr_en = 1'b1; ext_wr_data = 36'h0_1111_2222;
    src_not_empty = 1'b1; src_data = 36'hA_1234_5678; dst_not_full = 1'b1; settle();
    chk("R10", "src_rd_en", src_rd_en, 1);
    chk("R10", "port_oe", port_oe, 1);
    chk("R10", "port_out", port_out, 36'hA_1234_5678);
    chk("R10", "dst_wr_en ignored", dst_wr_en, 0);
    tick();
    src_not_empty = 1'b0; settle();
    chk("R12", "no pop when empty", src_rd_en, 0);
    chk("R10", "port_oe when empty", port_oe, 0);
    tick();
    ext_rd_en = 1'b0; src_not_empty = 1'b1; settle();
    chk("R10", "no pop without strobe", src_rd_en, 0);
  endtask

  task automatic t_pass_write();
    tick();
    port_rd_mode = 1'b0; ext_wr_en = 1'b1; ext_wr_data = 36'h5_5AA5_0F0F;
    ext_rd_en = 1'b1; src_not_empty = 1'b1; dst_not_full = 1'b1; settle();
    chk("R11", "dst_wr_en", dst_wr_en, 1);
    chk("R11", "dst_wr_data", dst_wr_data, 36'h5_5AA5_0F0F);
    chk("R11", "read strobe ignored", src_rd_en, 0);
    chk("R11", "port_oe", port_oe, 0);
    tick();
    dst_not_full = 1'b0; settle();
    chk("R12", "no write when full", dst_wr_en, 0);
  endtask

  task automatic t_enable_latency();
    tick();
    inputs_idle();
    src_not_empty = 1'b1; dst_not_full = 1'b1; src_data = 36'h3_0000_0003;
    loop_en = 1'b1; settle();
    chk("R2", "pop before edge", src_rd_en, 0);
    tick(); settle();
    chk("R2", "pop after edge", src_rd_en, 1);
    chk("R2", "write after edge", dst_wr_en, 1);
    loop_en = 1'b0; settle();
    chk("R2", "still looping before edge", dst_wr_en, 1);
    tick(); settle();
    chk("R2", "stopped after edge pop", src_rd_en, 0);
    chk("R2", "stopped after edge write", dst_wr_en, 0);
  endtask

  task automatic t_loop_write_mode();
    tick();
    loop_en = 1'b1; port_rd_mode = 1'b0;
    tick();
    src_not_empty = 1'b1; dst_not_full = 1'b1; src_data = 36'hC_AFE0_0001;
    ext_wr_en = 1'b1; ext_wr_data = 36'h0_BAD0_BAD0; settle();
    chk("R3", "pop", src_rd_en, 1);
    chk("R3", "write", dst_wr_en, 1);
    chk("R3", "write data", dst_wr_data, 36'hC_AFE0_0001);
    chk("R4", "port_oe", port_oe, 0);
    ext_wr_en = 1'b0;
  endtask

  task automatic t_loop_read_mode();
    tick();
    port_rd_mode = 1'b1; src_data = 36'h7_7777_0002; settle();
    chk("R5", "port_oe", port_oe, 1);
    chk("R5", "port_out", port_out, 36'h7_7777_0002);
    chk("R5", "write data", dst_wr_data, 36'h7_7777_0002);
  endtask

  task automatic t_dst_full();
    tick();
    dst_not_full = 1'b0; port_rd_mode = 1'b1; src_data = 36'hD_0000_00D0; settle();
    chk("R6", "pop", src_rd_en, 1);
    chk("R6", "port_oe", port_oe, 1);
    chk("R6", "port_out", port_out, 36'hD_0000_00D0);
    chk("R6", "no write", dst_wr_en, 0);
    tick();
    port_rd_mode = 1'b0; settle();
    chk("R7", "no pop", src_rd_en, 0);
    chk("R7", "no write", dst_wr_en, 0);
    chk("R7", "port_oe", port_oe, 0);
  endtask

  task automatic t_src_empty();
    tick();
    port_rd_mode = 1'b1; dst_not_full = 1'b1; src_not_empty = 1'b1;
    src_data = 36'hE_EEEE_0005;
    tick();
    src_not_empty = 1'b0; src_data = 36'hF_0BAD_F00D; settle();
    chk("R8", "refill write", dst_wr_en, 1);
    chk("R8", "refill data", dst_wr_data, 36'hE_EEEE_0005);
    chk("R8", "no pop", src_rd_en, 0);
    chk("R8", "port_oe", port_oe, 0);
    tick(); settle();
    chk("R8", "refill repeats", dst_wr_data, 36'hE_EEEE_0005);
    tick();
    dst_not_full = 1'b0; settle();
    chk("R8", "stops when full", dst_wr_en, 0);
  endtask

  task automatic t_no_last();
    tick();
    loop_en = 1'b0;
    tick();
    tick();
    loop_en = 1'b1; src_not_empty = 1'b0; dst_not_full = 1'b1; port_rd_mode = 1'b0;
    tick(); settle();
    chk("R9", "no write without popped word", dst_wr_en, 0);
    tick();
    src_not_empty = 1'b1; src_data = 36'h9_1357_9BDF;
    tick();
    src_not_empty = 1'b0; src_data = '0; settle();
    chk("R8", "refill after new pop", dst_wr_data, 36'h9_1357_9BDF);
    chk("R8", "refill write", dst_wr_en, 1);
    loop_en = 1'b0;
    tick(); settle();
    chk("R2", "refill stops after disable", dst_wr_en, 0);
  endtask

  initial begin
    #80000;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    inputs_idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_pass_read();
    t_pass_write();
    t_enable_latency();
    t_loop_write_mode();
    t_loop_read_mode();
    t_dst_full();
    t_src_empty();
    t_no_last();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule